// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a stereo PCM bit stream into parallel 24-bit left and right samples. It works entirely in the bit-clock domain. On each rising bit-clock edge it samples the word clock and the data line. A state machine follows which channel the current half-frame carries. A shift register keeps the most recent bits, and a per-half bit counter tells where in the half-frame the stream is.

Four framings are supported, selected by `fmt`:

| `fmt` | Framing | Word length |
|-------|---------|-------------|
| 00 | Right-justified, MSB first | 16, 20 or 24 bits, set by `wlen` |
| 01 | Left-justified, MSB first | 24 bits |
| 10 | Right-justified, LSB first | 24 bits |
| 11 | I2S | 24 bits |

Right-justified words are taken from the bits just before a word-clock change. Left-justified and I2S words are taken from the start of the half-frame. A single-cycle strobe marks each completed sample pair. A zero-mute input blanks both sample outputs.

The state machine has three states:
- `ST_IDLE`: entered on reset; nothing is captured.
- `ST_LEFT` and `ST_RIGHT`: one per channel.

Transitions:
- `ST_IDLE` moves to `ST_LEFT` or `ST_RIGHT` on the first word-clock change after reset. Which one depends on the new word-clock level.
- `ST_LEFT` moves to `ST_RIGHT`, and `ST_RIGHT` moves to `ST_LEFT`, on each later word-clock change.
- In the right-justified framings, the word of the half-frame being left is captured on that transition.
- In the other framings, capture happens inside the state when the bit counter reaches the end of the word.
- An unused encoding returns to `ST_IDLE`.

Top module: `pcm_rx_top`

## Requirements
- R1: While `rst_n` is low, `left_out`, `right_out` and `sample_valid` are zero, and the state machine is in `ST_IDLE`.
- R2: With `fmt`=00 (right-justified, MSB first), the word is the last N bits sampled before the rising bit-clock edge on which a new word-clock level is first seen. N is 16 for `wlen`=00, 20 for `wlen`=01 and 24 for `wlen`=1x. The earliest of those bits is the MSB, and the word is sign-extended to 24 bits.
- R3: With `fmt`=01 (left-justified), the word is the first 24 bits of a half-frame, MSB first. The first of them is the bit sampled on the edge where the new word-clock level is first seen. A high word clock means left.
- R4: With `fmt`=10, the word is the last 24 bits before the word-clock change. The earliest of them is the LSB. A high word clock means left.
- R5: With `fmt`=11 (I2S), the word is 24 bits, MSB first, beginning one bit clock after the word-clock change. A low word clock means left.
- R6: `sample_valid` is high for exactly one cycle, in the cycle after the right-channel word is captured. `right_out` shows the new word in that same cycle. `left_out` updates in the cycle after its own capture.
- R7: While `zero_mute` is high, `left_out` and `right_out` read zero. The captured words are kept, and they reappear when `zero_mute` falls.
- R8: The half-frame in progress when reset is released is discarded. No word is captured, and `sample_valid` stays low, until the first word-clock change has been seen.
- R9: `wlen` has no effect when `fmt` is not 00.
- R10: Bits of a half-frame that lie outside the selected word window do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word clock that selects the channel |
| sdata | input | 1 | Serial audio data |
| fmt | input | 2 | Framing select (00 RJ MSB, 01 LJ, 10 RJ LSB, 11 I2S) |
| wlen | input | 2 | Word length for `fmt`=00 (00:16, 01:20, 1x:24) |
| zero_mute | input | 1 | Forces both sample outputs to zero while high |
| left_out | output | 24 | Last captured left sample |
| right_out | output | 24 | Last captured right sample |
| sample_valid | output | 1 | One-cycle strobe after each completed pair |

## Verification
The assertions assume the following about the inputs:
- `fmt` and `wlen` stay constant outside `ST_IDLE`.
- The word clock alternates, with half-frames long enough to hold the word: at least 25 bit clocks in I2S, and at least N in the right-justified framings.
- The shift register always mirrors the data bit sampled one edge earlier.

The stimulus keeps within these limits:
- It changes the framing or word length only while reset is held.
- It uses 32-bit half-frames after an 11-bit partial half.
- It applies mute only between samples.
- It feeds random data, so bits outside the word window vary.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        FMT_RJ_MSB = 2'b00,
        FMT_LJ     = 2'b01,
        FMT_RJ_LSB = 2'b10,
        FMT_I2S    = 2'b11
    } rx_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } rx_state_e;

endpackage

// File: rtl/pcm_rx_frontend.sv
module pcm_rx_frontend #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                lrck,
    input  logic                sdata,
    output logic                lr_edge,
    output logic [CNT_W-1:0]    bit_idx,
    output logic [SAMPLE_W-1:0] shreg
);
    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    logic                primed_q;
    logic                lr_q;
    logic [SAMPLE_W-1:0] sh_q;
    logic [CNT_W-1:0]    cnt_q;

    // an edge counts only once a previous word-clock sample exists
    assign lr_edge = primed_q && (lrck != lr_q);
    assign bit_idx = lr_edge ? '0 : cnt_q;
    assign shreg   = sh_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            lr_q     <= 1'b0;
            sh_q     <= '0;
            cnt_q    <= '0;
        end else begin
            primed_q <= 1'b1;
            lr_q     <= lrck;
            sh_q     <= {sh_q[SAMPLE_W-2:0], sdata};
            if (bit_idx != IDX_MAX) begin
                cnt_q <= bit_idx + 1'b1;
            end
        end
    end

    // R2: the shift register holds the bit sampled on the previous edge
    a_r2_shift_tracks: assert property (@(posedge bclk) disable iff (!rst_n)
        primed_q |-> (sh_q[0] == $past(sdata)));

endmodule

// File: rtl/pcm_rx_extract.sv
module pcm_rx_extract
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  rx_fmt_e             fmt_sel,
    input  logic [1:0]          wlen,
    input  logic [SAMPLE_W-1:0] shreg,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] rj_word,
    output logic [SAMPLE_W-1:0] head_word
);
    localparam int W_SHORT = SAMPLE_W - 8;
    localparam int W_MID   = SAMPLE_W - 4;

    logic [SAMPLE_W-1:0] rev;

    // earliest bit in the window is the LSB in the LSB-first framing
    for (genvar g = 0; g < SAMPLE_W; g++) begin : g_rev
        assign rev[g] = shreg[SAMPLE_W-1-g];
    end

    // window that includes the bit arriving this edge
    assign head_word = {shreg[SAMPLE_W-2:0], sdata};

    always_comb begin
        if (fmt_sel == FMT_RJ_LSB) begin
            rj_word = rev;
        end else begin
            unique case (wlen)
                2'b00:   rj_word = SAMPLE_W'($signed(shreg[W_SHORT-1:0]));
                2'b01:   rj_word = SAMPLE_W'($signed(shreg[W_MID-1:0]));
                default: rj_word = shreg;
            endcase
        end
    end

endmodule

// File: rtl/pcm_rx_top.sv
module pcm_rx_top
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                lrck,
    input  logic                sdata,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wlen,
    input  logic                zero_mute,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    localparam logic [CNT_W-1:0] IDX_LJ_END  = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] IDX_I2S_END = CNT_W'(SAMPLE_W);

    rx_fmt_e             fmt_sel;
    rx_state_e           state_q, state_d, new_ch;
    logic                lr_edge;
    logic [CNT_W-1:0]    bit_idx, head_end;
    logic [SAMPLE_W-1:0] shreg, rj_word, head_word, cap_word;
    logic                is_rj, left_level, cap_left, cap_right;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic                valid_q;

    assign fmt_sel = rx_fmt_e'(fmt);

    pcm_rx_frontend #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_front (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .lrck    (lrck),
        .sdata   (sdata),
        .lr_edge (lr_edge),
        .bit_idx (bit_idx),
        .shreg   (shreg)
    );

    pcm_rx_extract #(.SAMPLE_W(SAMPLE_W)) u_extract (
        .fmt_sel   (fmt_sel),
        .wlen      (wlen),
        .shreg     (shreg),
        .sdata     (sdata),
        .rj_word   (rj_word),
        .head_word (head_word)
    );

    assign is_rj      = (fmt_sel == FMT_RJ_MSB) || (fmt_sel == FMT_RJ_LSB);
    assign left_level = (fmt_sel != FMT_I2S);
    assign new_ch     = (lrck == left_level) ? ST_LEFT : ST_RIGHT;
    assign head_end   = (fmt_sel == FMT_I2S) ? IDX_I2S_END : IDX_LJ_END;
    assign cap_word   = is_rj ? rj_word : head_word;

    // next state and capture decisions
    always_comb begin
        state_d   = state_q;
        cap_left  = 1'b0;
        cap_right = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (lr_edge) state_d = new_ch;
            end
            ST_LEFT: begin
                if (lr_edge) begin
                    state_d  = new_ch;
                    cap_left = is_rj;
                end else if (!is_rj && bit_idx == head_end) begin
                    cap_left = 1'b1;
                end
            end
            ST_RIGHT: begin
                if (lr_edge) begin
                    state_d   = new_ch;
                    cap_right = is_rj;
                end else if (!is_rj && bit_idx == head_end) begin
                    cap_right = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= cap_right;
            if (cap_left)  left_q  <= cap_word;
            if (cap_right) right_q <= cap_word;
        end
    end

    assign left_out     = zero_mute ? '0 : left_q;
    assign right_out    = zero_mute ? '0 : right_q;
    assign sample_valid = valid_q;

    // R6: strobe lasts one cycle
    a_r6_valid_single: assert property (@(posedge bclk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R6: strobe only follows a right-channel half
    a_r6_valid_from_right: assert property (@(posedge bclk) disable iff (!rst_n)
        sample_valid |-> ($past(state_q) == ST_RIGHT));

    // R8: nothing is reported while still waiting for the first edge
    a_r8_idle_silent: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !sample_valid);

    // R8: the first edge ends the idle wait
    a_r8_edge_leaves_idle: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_IDLE && lr_edge) |=> (state_q != ST_IDLE));

    // R9: configuration held constant while receiving
    a_r9_cfg_stable: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> ($stable(fmt) && $stable(wlen)));

endmodule

// File: tb/tb_pcm_rx_top.sv
module tb_pcm_rx_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_LEN   = 32;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic        zero_mute = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [1:0]  wlen = 2'b00;
    logic [23:0] left_out, right_out;
    logic        sample_valid;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    pcm_rx_top dut (
        .bclk         (bclk),
        .rst_n        (rst_n),
        .lrck         (lrck),
        .sdata        (sdata),
        .fmt          (fmt),
        .wlen         (wlen),
        .zero_mute    (zero_mute),
        .left_out     (left_out),
        .right_out    (right_out),
        .sample_valid (sample_valid)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";

    // behavioural reference
    bit          first_s;
    bit          prev_lr;
    bit          active;
    bit          chan_left;
    bit          cur[$];
    logic [23:0] exp_l, exp_r;
    bit          exp_v;

    task automatic check_val(string req, string what, logic [23:0] got, logic [23:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        check_val(tag, "left",  left_out,  zero_mute ? 24'h0 : exp_l);
        check_val(tag, "right", right_out, zero_mute ? 24'h0 : exp_r);
        check_val("R6/R8", "valid", {23'b0, sample_valid}, {23'b0, exp_v});
    endtask

    function automatic logic [23:0] rj_word();
        logic [23:0] w = '0;
        int n  = (fmt == 2'b00) ? ((wlen == 2'b00) ? 16 : (wlen == 2'b01) ? 20 : 24) : 24;
        int sz = cur.size();
        if (fmt == 2'b10) begin
            for (int i = 0; i < 24; i++) w[i] = cur[sz-24+i];
        end else begin
            for (int k = 0; k < n; k++) w[n-1-k] = cur[sz-n+k];
            for (int k = n; k < 24; k++) w[k] = w[n-1];
        end
        return w;
    endfunction

    function automatic logic [23:0] head_word(int off);
        logic [23:0] w = '0;
        for (int k = 0; k < 24; k++) w[23-k] = cur[off+k];
        return w;
    endfunction

    task automatic model_reset();
        first_s = 1'b1;
        active  = 1'b0;
        cur.delete();
        exp_l = '0;
        exp_r = '0;
        exp_v = 1'b0;
    endtask

    task automatic store(logic [23:0] w);
        if (chan_left) exp_l = w;
        else begin
            exp_r = w;
            exp_v = 1'b1;
        end
    endtask

    task automatic model_update(bit lr, bit d);
        bit rj = (fmt == 2'b00) || (fmt == 2'b10);
        exp_v = 1'b0;
        if (first_s) begin
            first_s = 1'b0;
            prev_lr = lr;
            cur.push_back(d);
        end else if (lr != prev_lr) begin
            if (active && rj) store(rj_word());
            cur.delete();
            cur.push_back(d);
            active    = 1'b1;
            chan_left = (fmt == 2'b11) ? (lr == 1'b0) : (lr == 1'b1);
            prev_lr   = lr;
        end else begin
            cur.push_back(d);
            if (active && !rj) begin
                if (fmt == 2'b01 && cur.size() == 24) store(head_word(0));
                if (fmt == 2'b11 && cur.size() == 25) store(head_word(1));
            end
        end
    endtask

    task automatic step(bit lr, bit d);
        @(negedge bclk);
        compare_all();
        lrck  = lr;
        sdata = d;
        @(posedge bclk);
        #1;
        model_update(lr, d);
    endtask

    task automatic do_reset(logic [1:0] f, logic [1:0] w);
        @(negedge bclk);
        rst_n = 1'b0;
        fmt = f;
        wlen = w;
        lrck = 1'b0;
        sdata = 1'b0;
        zero_mute = 1'b0;
        model_reset();
        repeat (2) @(negedge bclk);
        tag = "R1";
        compare_all();
        rst_n = 1'b1;
        @(posedge bclk);
        #1;
        model_update(1'b0, 1'b0);
    endtask

    // R8: an 11-bit partial half first; R10: random bits fill each 32-bit half
    task automatic run_stream(string t, int nhalves);
        bit lr = lrck;
        tag = t;
        for (int i = 0; i < 11; i++) step(lr, bit'($urandom % 2));
        for (int h = 0; h < nhalves; h++) begin
            lr = ~lr;
            for (int i = 0; i < HALF_LEN; i++) step(lr, bit'($urandom % 2));
        end
        step(lr, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset(2'b00, 2'b00); run_stream("R2", 8);
        do_reset(2'b00, 2'b01); run_stream("R2", 8);
        do_reset(2'b00, 2'b10); run_stream("R2", 8);
        do_reset(2'b00, 2'b11); run_stream("R2", 6);
        do_reset(2'b01, 2'b10); run_stream("R3", 8);
        do_reset(2'b01, 2'b00); run_stream("R9", 6);
        do_reset(2'b10, 2'b10); run_stream("R4", 8);
        do_reset(2'b10, 2'b01); run_stream("R9", 6);
        do_reset(2'b11, 2'b10); run_stream("R5", 8);
        do_reset(2'b11, 2'b00); run_stream("R9", 6);
        // R7: mute blanks outputs, release restores held samples
        do_reset(2'b01, 2'b10);
        run_stream("R7", 4);
        zero_mute = 1'b1;
        run_stream("R7", 4);
        zero_mute = 1'b0;
        run_stream("R7", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule